// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox

This block gives two independently clocked ports a pair of one-word message registers. These registers sit beside a data queue. The forward register carries a word from the A side to the B side. The return register carries a word from B to A. Each port has four access controls:

- an active-low chip select,
- a direction bit,
- an enable,
- a mailbox-select bit.

When mailbox select is set, the port's access goes to a mail register instead of the queue.

Each register has a "free" flag that lives in the writer's clock domain. A write clears the flag. The flag returns high only after the opposite port has read the word. That read travels back through a toggle handshake with two-flop synchronizers. While the flag is low, the writer cannot overwrite the word. Reading never alters the stored data.

On reads, each port's data output selects either the queue output word or the incoming mail register. The output is zero when the port is not driving.

Top module: `xclk_mailbox`

## Requirements
- R1: On a rising `clk_a` edge with `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbx`=1 and `ab_free`=1, `a_wdata` is stored as the forward mail word.
- R2: On a rising `clk_b` edge with `b_cs_n`=0, `b_wr`=1, `b_en`=1, `b_mbx`=1 and `ba_free`=1, `b_wdata` is stored as the return mail word.
- R3: A write accepted under R1 or R2 drives the writer's free flag (`ab_free` or `ba_free`) low from that same clock edge onwards.
- R4: A mailbox write attempted while the target free flag is 0 leaves the stored word and the flag unchanged.
- R5: A qualified mailbox read (`cs_n`=0, `wr`=0, `en`=1, `mbx`=1) on the opposite port releases the word. This holds only when the read comes at least three reader clocks after the write. The writer's free flag then returns to 1 within three writer clocks after the read edge. A read made in the first two reader clocks after the write has no effect on the flag.
- R6: A port drives its data output while `cs_n`=0 and `wr`=0. In that state the output is the incoming mail word when `mbx`=1 and the port's queue word (`a_fifo_q`/`b_fifo_q`) when `mbx`=0. Otherwise the output is all zeros.
- R7: Reading a mail register never changes its contents.
- R8: After synchronous active-low reset, both free flags are 1 and both mail words are zero.
- R9: Accesses with `mbx`=0, `en`=0 or `cs_n`=1 neither write a mail word nor release a free flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output word for port A |
| a_rdata | output | 36 | Port A read data |
| ab_free | output | 1 | Forward mail register empty (1) / holding (0) |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B access enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output word for port B |
| b_rdata | output | 36 | Port B read data |
| ba_free | output | 1 | Return mail register empty (1) / holding (0) |

## Verification
The hardest case to reach is a read that arrives before the write's toggle has crossed into the reader's domain. That read must leave the flag low. The stimulus produces it directly: it issues a B-side mailbox read on the first or second B edge after the A-side write edge, then lets both domains settle and checks that `ab_free` is still low. A later read then releases the word. Random traffic mixes select, enable and mailbox bits on both ports, with settling gaps, so that a bench model tracks every flag and word exactly.

// File: rtl/mbx_pkg.sv
// Package: shared types for the dual-clock mailbox.
// Assumes nothing beyond a single port's control inputs.
package mbx_pkg;

    // Decoded meaning of one port's access controls in the current cycle
    typedef struct packed {
        logic mail_wr;   // qualified write to the outgoing mail register
        logic mail_rd;   // qualified read of the incoming mail register
        logic drive;     // port data output is active
    } mbx_access_t;

endpackage

// File: rtl/mbx_sync.sv
// Module: mbx_sync
// Multi-flop synchronizer for a single level signal into the clock domain
// of clk. Assumes the input changes at most once per several destination
// clocks (true for a handshake toggle). STAGES must be at least 2.
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the foreign-domain level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages let metastability resolve
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_port_ctrl.sv
// Module: mbx_port_ctrl
// Decodes one port's select/direction/enable/mailbox-select inputs into
// mailbox write/read strobes and selects the port's read data between the
// queue output word and the incoming mail word.
// Assumes all inputs are synchronous to this port's clock.
module mbx_port_ctrl
    import mbx_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         cs_n,
    input  logic         wr,
    input  logic         en,
    input  logic         mbx,
    input  logic [W-1:0] fifo_q,
    input  logic [W-1:0] mail_in,
    output mbx_access_t  acc,
    output logic [W-1:0] rdata
);
    // Qualify the access strobes from the raw port controls
    always_comb begin
        acc.drive   = !cs_n && !wr;
        acc.mail_wr = !cs_n &&  wr && en && mbx;
        acc.mail_rd = !cs_n && !wr && en && mbx;
    end

    // Steer read data: mail word, queue word, or idle zero
    always_comb begin
        if (!acc.drive)  rdata = '0;
        else if (mbx)    rdata = mail_in;
        else             rdata = fifo_q;
    end
endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One-word mail register crossing from a writer clock to a reader clock.
// The writer flips wr_tgl on each accepted write. The reader flips
// ack_tgl when it reads while a synchronized write is pending.
// The register is free exactly when the two toggles agree, seen from the
// writer side. Data crosses without synchronizers because it is frozen
// while the word is held.
// Assumes both domain resets are applied together.
module mbx_slot #(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    output logic         free,
    output logic [W-1:0] data,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_req
);
    logic wr_tgl;
    logic ack_tgl;
    logic wr_tgl_r;   // wr_tgl seen in reader domain
    logic ack_tgl_w;  // ack_tgl seen in writer domain
    logic pending_r;

    // Writer: capture the word and flip the write toggle on an accepted write
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wr_tgl <= 1'b0;
            data   <= '0;
        end else if (wr_req && free) begin
            wr_tgl <= ~wr_tgl;
            data   <= wdata;
        end
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wr_tgl),
        .q     (wr_tgl_r)
    );

    assign pending_r = (wr_tgl_r != ack_tgl);

    // Reader: acknowledge a read only when a write is visibly pending
    always_ff @(posedge rclk) begin
        if (!rrst_n)                    ack_tgl <= 1'b0;
        else if (rd_req && pending_r)   ack_tgl <= ~ack_tgl;
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (ack_tgl),
        .q     (ack_tgl_w)
    );

    assign free = (wr_tgl == ack_tgl_w);
endmodule

// File: rtl/xclk_mailbox.sv
// Module: xclk_mailbox
// Top: two mail registers between port A (clk_a) and port B (clk_b).
// Forward register: written by A, read by B, flag ab_free in A domain.
// Return register: written by B, read by A, flag ba_free in B domain.
// Assumes rst_a_n and rst_b_n are asserted together for at least
// SYNC_STAGES cycles of the slower clock.
module xclk_mailbox
    import mbx_pkg::*;
#(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         rst_a_n,
    input  logic         a_cs_n,
    input  logic         a_wr,
    input  logic         a_en,
    input  logic         a_mbx,
    input  logic [W-1:0] a_wdata,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_rdata,
    output logic         ab_free,
    input  logic         clk_b,
    input  logic         rst_b_n,
    input  logic         b_cs_n,
    input  logic         b_wr,
    input  logic         b_en,
    input  logic         b_mbx,
    input  logic [W-1:0] b_wdata,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_rdata,
    output logic         ba_free
);
    mbx_access_t acc_a;
    mbx_access_t acc_b;
    logic [W-1:0] mail_ab;
    logic [W-1:0] mail_ba;

    mbx_port_ctrl #(.W(W)) u_port_a (
        .cs_n    (a_cs_n),
        .wr      (a_wr),
        .en      (a_en),
        .mbx     (a_mbx),
        .fifo_q  (a_fifo_q),
        .mail_in (mail_ba),
        .acc     (acc_a),
        .rdata   (a_rdata)
    );

    mbx_port_ctrl #(.W(W)) u_port_b (
        .cs_n    (b_cs_n),
        .wr      (b_wr),
        .en      (b_en),
        .mbx     (b_mbx),
        .fifo_q  (b_fifo_q),
        .mail_in (mail_ab),
        .acc     (acc_b),
        .rdata   (b_rdata)
    );

    mbx_slot #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_slot_ab (
        .wclk   (clk_a),
        .wrst_n (rst_a_n),
        .wr_req (acc_a.mail_wr),
        .wdata  (a_wdata),
        .free   (ab_free),
        .data   (mail_ab),
        .rclk   (clk_b),
        .rrst_n (rst_b_n),
        .rd_req (acc_b.mail_rd)
    );

    mbx_slot #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_slot_ba (
        .wclk   (clk_b),
        .wrst_n (rst_b_n),
        .wr_req (acc_b.mail_wr),
        .wdata  (b_wdata),
        .free   (ba_free),
        .data   (mail_ba),
        .rclk   (clk_a),
        .rrst_n (rst_a_n),
        .rd_req (acc_a.mail_rd)
    );
endmodule

// File: rtl/xclk_mailbox_chk.sv
// Module: xclk_mailbox_chk
// Property checker bound into xclk_mailbox. It observes the ports and the
// two stored mail words.
module xclk_mailbox_chk #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         rst_a_n,
    input logic         a_cs_n,
    input logic         a_wr,
    input logic         a_en,
    input logic         a_mbx,
    input logic [W-1:0] a_wdata,
    input logic [W-1:0] a_fifo_q,
    input logic [W-1:0] a_rdata,
    input logic         ab_free,
    input logic         clk_b,
    input logic         rst_b_n,
    input logic         b_cs_n,
    input logic         b_wr,
    input logic         b_en,
    input logic         b_mbx,
    input logic [W-1:0] b_wdata,
    input logic [W-1:0] b_fifo_q,
    input logic [W-1:0] b_rdata,
    input logic         ba_free,
    input logic [W-1:0] mail_ab,
    input logic [W-1:0] mail_ba
);
    logic a_try_wr;
    logic b_try_wr;
    assign a_try_wr = !a_cs_n && a_wr && a_en && a_mbx;
    assign b_try_wr = !b_cs_n && b_wr && b_en && b_mbx;

    assert_ab_capture_R1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_try_wr && ab_free) |=> (mail_ab == $past(a_wdata)));
    assert_ba_capture_R2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_try_wr && ba_free) |=> (mail_ba == $past(b_wdata)));

    assert_ab_flag_low_R3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_try_wr && ab_free) |=> !ab_free);
    assert_ba_flag_low_R3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_try_wr && ba_free) |=> !ba_free);
    assert_ab_fall_cause_R3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $fell(ab_free) |-> $past(a_try_wr));

    assert_ab_blocked_R4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!ab_free) |=> $stable(mail_ab));
    assert_ba_blocked_R4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!ba_free) |=> $stable(mail_ba));

    assert_a_read_mux_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_cs_n && !a_wr) |-> (a_rdata == (a_mbx ? mail_ba : a_fifo_q)));
    assert_b_read_mux_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!b_cs_n && !b_wr) |-> (b_rdata == (b_mbx ? mail_ab : b_fifo_q)));
    assert_a_idle_zero_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_cs_n || a_wr) |-> (a_rdata == '0));

    assert_ab_keep_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_try_wr) |=> $stable(mail_ab));
    assert_ba_keep_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!b_try_wr) |=> $stable(mail_ba));

    assert_a_reset_R8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $past(!rst_a_n) |-> (ab_free && mail_ab == '0));
    assert_b_reset_R8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $past(!rst_b_n) |-> (ba_free && mail_ba == '0));
endmodule

bind xclk_mailbox xclk_mailbox_chk #(.W(W)) u_chk (
    .clk_a    (clk_a),
    .rst_a_n  (rst_a_n),
    .a_cs_n   (a_cs_n),
    .a_wr     (a_wr),
    .a_en     (a_en),
    .a_mbx    (a_mbx),
    .a_wdata  (a_wdata),
    .a_fifo_q (a_fifo_q),
    .a_rdata  (a_rdata),
    .ab_free  (ab_free),
    .clk_b    (clk_b),
    .rst_b_n  (rst_b_n),
    .b_cs_n   (b_cs_n),
    .b_wr     (b_wr),
    .b_en     (b_en),
    .b_mbx    (b_mbx),
    .b_wdata  (b_wdata),
    .b_fifo_q (b_fifo_q),
    .b_rdata  (b_rdata),
    .ba_free  (ba_free),
    .mail_ab  (mail_ab),
    .mail_ba  (mail_ba)
);

// File: tb/xclk_mailbox_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a bench model of both mail words and both free flags.
module xclk_mailbox_test;
    localparam int W        = 36;
    localparam int PERIOD_A = 10;
    localparam int PERIOD_B = 14;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
    logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic ab_free, ba_free;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // bench model
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_ab_full = 1'b0, m_ba_full = 1'b0;

    always #(PERIOD_A/2) clk_a = ~clk_a;
    always #(PERIOD_B/2) clk_b = ~clk_b;

    xclk_mailbox #(.W(W)) uut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_cs_n(a_cs_n), .a_wr(a_wr),
        .a_en(a_en), .a_mbx(a_mbx), .a_wdata(a_wdata), .a_fifo_q(a_fifo_q),
        .a_rdata(a_rdata), .ab_free(ab_free),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_cs_n(b_cs_n), .b_wr(b_wr),
        .b_en(b_en), .b_mbx(b_mbx), .b_wdata(b_wdata), .b_fifo_q(b_fifo_q),
        .b_rdata(b_rdata), .ba_free(ba_free)
    );

    function automatic logic [W-1:0] exp_rdata(input logic cs_n, input logic wr,
                                               input logic mbx, input logic [W-1:0] mail,
                                               input logic [W-1:0] fifo);
        if (cs_n || wr) return '0;
        return mbx ? mail : fifo;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom} & {W{1'b1}};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One port A cycle; the read output is checked before the edge; the model
    // is updated only when upd is set (settled case)
    task automatic a_op(input logic cs_n, input logic wr, input logic en, input logic mbx,
                        input logic [W-1:0] d, input logic upd, input string req);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx; a_wdata = d;
        a_fifo_q = rnd_word();
        #1;
        check(req, a_rdata, exp_rdata(cs_n, wr, mbx, m_ba, a_fifo_q));
        @(posedge clk_a);
        #1;
        a_cs_n = 1'b1; a_en = 1'b0;
        if (!cs_n && en && mbx) begin
            if (wr && !m_ab_full) begin m_ab = d; m_ab_full = 1'b1; end
            else if (!wr && upd)  m_ba_full = 1'b0;
        end
    endtask

    task automatic b_op(input logic cs_n, input logic wr, input logic en, input logic mbx,
                        input logic [W-1:0] d, input logic upd, input string req);
        @(negedge clk_b);
        b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = mbx; b_wdata = d;
        b_fifo_q = rnd_word();
        #1;
        check(req, b_rdata, exp_rdata(cs_n, wr, mbx, m_ab, b_fifo_q));
        @(posedge clk_b);
        #1;
        b_cs_n = 1'b1; b_en = 1'b0;
        if (!cs_n && en && mbx) begin
            if (wr && !m_ba_full) begin m_ba = d; m_ba_full = 1'b1; end
            else if (!wr && upd)  m_ab_full = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk_b);
    endtask

    // Compare flags and both stored words (read with enable low) to the model
    task automatic audit(input string req_flag, input string req_ab, input string req_ba);
        settle();
        check(req_flag, W'(ab_free), W'(!m_ab_full));
        check(req_flag, W'(ba_free), W'(!m_ba_full));
        b_op(1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b1, req_ab);
        a_op(1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b1, req_ba);
    endtask

    initial begin
        logic [W-1:0] d1, d2, e1, d3;
        void'($urandom(32'd4177));
        repeat (6) @(negedge clk_b);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        repeat (2) @(negedge clk_b);

        // R8: reset state
        audit("R8", "R8", "R8");

        // R1 / R3: forward write
        d1 = rnd_word();
        a_op(1'b0, 1'b1, 1'b1, 1'b1, d1, 1'b1, "R6");
        audit("R3", "R1", "R8");

        // R4: second write while holding is ignored
        d2 = ~d1;
        a_op(1'b0, 1'b1, 1'b1, 1'b1, d2, 1'b1, "R6");
        audit("R4", "R4", "R8");

        // R9: queue read and disabled mailbox read leave the flag low
        b_op(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b1, "R6");
        b_op(1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b1, "R6");
        b_op(1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b1, "R6");
        audit("R9", "R9", "R9");

        // R5 / R7: real read releases the word and keeps the data
        b_op(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b1, "R6");
        audit("R5", "R7", "R8");

        // R2 / R3: return write
        e1 = rnd_word();
        b_op(1'b0, 1'b1, 1'b1, 1'b1, e1, 1'b1, "R6");
        audit("R3", "R7", "R2");

        // R9: queue-select write on A does not touch the forward word
        a_op(1'b0, 1'b1, 1'b1, 1'b0, rnd_word(), 1'b1, "R6");
        audit("R9", "R9", "R2");

        // R5: read issued before the write toggle crosses has no effect
        d3 = rnd_word();
        a_op(1'b0, 1'b1, 1'b1, 1'b1, d3, 1'b1, "R6");
        b_op(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b0, "R6");
        audit("R5", "R1", "R2");
        b_op(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b1, "R6");
        a_op(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b1, "R6");
        audit("R5", "R7", "R7");

        // Random traffic on both ports
        for (int i = 0; i < 150; i++) begin
            logic cs_n, wr, en, mbx;
            cs_n = ($urandom % 8) == 0;
            wr   = $urandom % 2;
            en   = ($urandom % 6) != 0;
            mbx  = ($urandom % 4) != 0;
            if ($urandom % 2) a_op(cs_n, wr, en, mbx, rnd_word(), 1'b1, "R6");
            else              b_op(cs_n, wr, en, mbx, rnd_word(), 1'b1, "R6");
            audit("R3", "R1", "R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(PERIOD_B * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule